// File: doc/BRIEF.md
# UART FIFO Control and Interrupt Flags

This block holds the FIFO control settings of one 16550-style UART channel, together with the channel's transmit and receive FIFOs, and it derives the two interrupt flags from them. A host writes an 8-bit control word. That word enables the FIFOs and requests self-clearing resets of either FIFO. It also picks one of two interrupt modes and chooses a transmit trigger level. The transmitter side pushes characters and the shift logic pops them. The receive side works the other way round: the line logic pushes characters, the host pops them, and a separate receive-timeout strobe arrives from outside.

In single-character mode, and whenever the FIFOs are disabled, the flags follow plain occupancy. In block mode the flags follow trigger levels instead, which suits burst transfers. While the FIFOs are disabled, each direction holds only one character, the way a plain holding register does.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the control readback is 0x00, both counts are 0, the overflow flags are 0, `tx_empty_irq` is 1 and `rx_ready_irq` is 0.
- R2: A control write with bit 0 = 0 changes only the enable bit (bit 0). Bits 5:3 keep their values, and the reset requests in bits 1 and 2 are ignored, so no FIFO is cleared.
- R3: A write with bits 0 and 1 set clears the receive FIFO. Readback bit 1 reads 1 in the cycle after the write and 0 one cycle later. In that later cycle `rx_count` and `rx_overflow` are 0 and the transmit FIFO is untouched.
- R4: A write with bits 0 and 2 set clears the transmit FIFO in the same way. The clear shows on readback bit 2, `tx_count` and `tx_overflow`, and the receive FIFO is untouched.
- R5: When a push lands in the same cycle as a FIFO clear, the clear wins and the count ends at 0.
- R6: With bit 0 = 0 each FIFO holds at most one character. A second push is dropped and sets that direction's overflow flag.
- R7: In mode 0 (bit 3 = 0) or with the FIFOs disabled, `tx_empty_irq` = (`tx_count` == 0) and `rx_ready_irq` = (`rx_count` != 0). `rx_timeout` has no effect.
- R8: In mode 1 with the FIFOs enabled, `tx_empty_irq` = (`tx_count` < level). The level comes from bits 5:4: 00 gives 16, 01 gives 8, 10 gives 24 and 11 gives 30.
- R9: In mode 1 with the FIFOs enabled, `rx_ready_irq` is 1 when `rx_count` >= RX_TRIG (default 8) or when `rx_timeout` is 1.
- R10: An enabled FIFO keeps accepting characters past its trigger level until it holds 64. A push while full is dropped and sets a sticky overflow flag.
- R11: Each FIFO returns characters in the order they were written, and `*_out` shows the oldest character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word: bit0 enable, bit1 rx clear, bit2 tx clear, bit3 mode, bits5:4 tx level |
| cfg_rdata | output | 8 | Control word readback |
| tx_push | input | 1 | Host writes a transmit character |
| tx_data | input | 8 | Transmit character |
| tx_pop | input | 1 | Shift logic takes the oldest transmit character |
| tx_out | output | 8 | Oldest transmit character |
| tx_count | output | 7 | Transmit occupancy |
| tx_full | output | 1 | Transmit FIFO cannot accept a character |
| tx_overflow | output | 1 | Sticky: a transmit push was dropped |
| rx_push | input | 1 | Line logic delivers a received character |
| rx_data | input | 8 | Received character |
| rx_pop | input | 1 | Host reads the oldest received character |
| rx_out | output | 8 | Oldest received character |
| rx_count | output | 7 | Receive occupancy |
| rx_full | output | 1 | Receive FIFO cannot accept a character |
| rx_overflow | output | 1 | Sticky: a receive push was dropped |
| rx_timeout | input | 1 | Receive timeout strobe |
| tx_empty_irq | output | 1 | Transmit-empty interrupt flag |
| rx_ready_irq | output | 1 | Receive-ready interrupt flag |

## Verification
The hardest case to reach from the ports is a push that lands in exactly the cycle in which a requested clear takes effect. That cycle is one clock after the control write, not the write cycle itself. The bench lowers the write strobe and raises `rx_push` on the same falling edge, so the push meets the pending clear on the following rising edge. Two other cases also need deliberate stimulus: a full 64-entry receive FIFO, which the bench reaches by filling past the trigger level, and changing the trigger level while the occupancy stays fixed.

// File: rtl/ufc_pkg.sv
// Package: control word layout and transmit trigger-level decode shared by
// the FIFO control block. Assumes a FIFO depth that is a multiple of 32.
package ufc_pkg;

    // Control word, bit 0 at the bottom; positions are decoded by the host.
    typedef struct packed {
        logic [1:0] tx_trig;   // bits 5:4
        logic       blk_mode;  // bit 3
        logic       tx_clr;    // bit 2
        logic       rx_clr;    // bit 1
        logic       fifo_en;   // bit 0
    } ctl_word_t;

    // Transmit trigger level for a given code, scaled to the FIFO depth.
    function automatic int unsigned tx_level(input logic [1:0] code,
                                             input int unsigned depth);
        case (code)
            2'b00:   return depth / 4;
            2'b01:   return depth / 8;
            2'b10:   return (depth * 3) / 8;
            default: return depth / 2 - depth / 32;
        endcase
    endfunction

endpackage

// File: rtl/ufc_ctl_reg.sv
// Module: control word register. Bit 0 is always written; the other bits
// only when the same write sets bit 0. The clear requests are one-cycle
// pulses that drop back to 0 on the next clock.
module ufc_ctl_reg
    import ufc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  logic [7:0] wdata,
    output ctl_word_t ctl
);

    ctl_word_t ctl_q;

    // Capture the control word and retire clear requests after one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q.rx_clr <= 1'b0;
            ctl_q.tx_clr <= 1'b0;
            if (wr) begin
                ctl_q.fifo_en <= wdata[0];
                if (wdata[0]) begin
                    ctl_q.rx_clr   <= wdata[1];
                    ctl_q.tx_clr   <= wdata[2];
                    ctl_q.blk_mode <= wdata[3];
                    ctl_q.tx_trig  <= wdata[5:4];
                end
            end
        end
    end

    assign ctl = ctl_q;

    // R2: a write without the enable bit leaves the gated bits alone.
    a_r2_gated_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !wdata[0] |=> $stable(ctl_q.blk_mode) && $stable(ctl_q.tx_trig)
                            && !ctl_q.rx_clr && !ctl_q.tx_clr);

    // R3: the receive clear request lasts one cycle without a new write.
    a_r3_clear_selfclears: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.rx_clr && !wr |=> !ctl_q.rx_clr);

endmodule

// File: rtl/ufc_fifo.sv
// Module: synchronous FIFO with an occupancy counter and a sticky overflow
// flag. In single mode it holds one entry like a holding register. A clear
// empties it and beats a push in the same cycle. Assumes DEPTH is a power of 2.
module ufc_fifo #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             single,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             overflow
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt_q;
    logic             ovf_q;
    logic             do_push, do_pop;

    // Capacity limit: one entry in single mode, DEPTH otherwise.
    always_comb full = single ? (cnt_q != '0) : (cnt_q == CW'(DEPTH));

    // Accepted transfers; a clear suppresses both.
    always_comb begin
        do_push = push && !full && !clr;
        do_pop  = pop && (cnt_q != '0) && !clr;
    end

    // Storage write port.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointers, occupancy and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
            if (push && full) ovf_q <= 1'b1;
        end
    end

    assign dout     = mem[rd_ptr];
    assign count    = cnt_q;
    assign overflow = ovf_q;

    // R10: a push into a full FIFO leaves the count alone and flags overflow.
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop && !clr |=> count == $past(count) && overflow);

    // R3/R4/R5: a clear empties the FIFO whatever else happens that cycle.
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0 && !overflow);

    // R10: occupancy never exceeds the depth.
    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

// File: rtl/ufc_irq.sv
// Module: interrupt flag derivation. Mode 0 or FIFOs disabled: flags follow
// plain occupancy. Mode 1 with FIFOs on: flags follow trigger levels, and the
// receive flag also follows the timeout strobe. Purely combinational.
module ufc_irq
    import ufc_pkg::*;
#(
    parameter int unsigned DEPTH   = 64,
    parameter int unsigned RX_TRIG = 8,
    localparam int unsigned CW     = $clog2(DEPTH) + 1
) (
    input  ctl_word_t      ctl,
    input  logic [CW-1:0]  tx_count,
    input  logic [CW-1:0]  rx_count,
    input  logic           rx_timeout,
    output logic           tx_empty,
    output logic           rx_ready
);

    logic          block;
    logic [CW-1:0] tx_lvl;

    // Selected transmit level and effective mode.
    always_comb begin
        block  = ctl.fifo_en && ctl.blk_mode;
        tx_lvl = CW'(tx_level(ctl.tx_trig, DEPTH));
    end

    // Flag equations for both modes.
    always_comb begin
        if (block) begin
            tx_empty = tx_count < tx_lvl;
            rx_ready = (rx_count >= CW'(RX_TRIG)) || rx_timeout;
        end else begin
            tx_empty = tx_count == '0;
            rx_ready = rx_count != '0;
        end
    end

endmodule

// File: rtl/uart_fifo_ctrl.sv
// Module: top of the UART FIFO control block. Joins the control register,
// the two FIFOs and the interrupt logic. Assumes a single clock domain and
// that the host and the line logic honour the full flags where they care.
module uart_fifo_ctrl
    import ufc_pkg::*;
#(
    parameter int unsigned DEPTH   = 64,
    parameter int unsigned WIDTH   = 8,
    parameter int unsigned RX_TRIG = 8,
    localparam int unsigned CW     = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             tx_push,
    input  logic [WIDTH-1:0] tx_data,
    input  logic             tx_pop,
    output logic [WIDTH-1:0] tx_out,
    output logic [CW-1:0]    tx_count,
    output logic             tx_full,
    output logic             tx_overflow,
    input  logic             rx_push,
    input  logic [WIDTH-1:0] rx_data,
    input  logic             rx_pop,
    output logic [WIDTH-1:0] rx_out,
    output logic [CW-1:0]    rx_count,
    output logic             rx_full,
    output logic             rx_overflow,
    input  logic             rx_timeout,
    output logic             tx_empty_irq,
    output logic             rx_ready_irq
);

    ctl_word_t ctl;

    ufc_ctl_reg i_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .ctl   (ctl)
    );

    ufc_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_tx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctl.tx_clr),
        .single   (!ctl.fifo_en),
        .push     (tx_push),
        .din      (tx_data),
        .pop      (tx_pop),
        .dout     (tx_out),
        .count    (tx_count),
        .full     (tx_full),
        .overflow (tx_overflow)
    );

    ufc_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_rx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctl.rx_clr),
        .single   (!ctl.fifo_en),
        .push     (rx_push),
        .din      (rx_data),
        .pop      (rx_pop),
        .dout     (rx_out),
        .count    (rx_count),
        .full     (rx_full),
        .overflow (rx_overflow)
    );

    ufc_irq #(.DEPTH(DEPTH), .RX_TRIG(RX_TRIG)) i_irq (
        .ctl        (ctl),
        .tx_count   (tx_count),
        .rx_count   (rx_count),
        .rx_timeout (rx_timeout),
        .tx_empty   (tx_empty_irq),
        .rx_ready   (rx_ready_irq)
    );

    assign cfg_rdata = {2'b00, ctl};

    // R7: in occupancy mode, popping the last transmit character raises the flag.
    a_r7_last_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.fifo_en && ctl.blk_mode) && !cfg_wr && tx_count == CW'(1)
        && tx_pop && !tx_push && !ctl.tx_clr |=> tx_empty_irq);

    // R9: in block mode a timeout strobe always presents receive-ready.
    a_r9_timeout_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.fifo_en && ctl.blk_mode && rx_timeout |-> rx_ready_irq);

    // R8: an empty transmit FIFO always requests data in block mode.
    a_r8_empty_requests: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.fifo_en && ctl.blk_mode && tx_count == '0 |-> tx_empty_irq);

endmodule

// File: tb/test_uart_fifo_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module test_uart_fifo_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_data = '0, rx_data = '0, tx_out, rx_out;
    logic [6:0] tx_count, rx_count;
    logic       tx_full, tx_overflow, rx_full, rx_overflow;
    logic       rx_timeout = 1'b0;
    logic       tx_empty_irq, rx_ready_irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_fifo_ctrl i_uart_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tx_push(tx_push), .tx_data(tx_data),
        .tx_pop(tx_pop), .tx_out(tx_out), .tx_count(tx_count),
        .tx_full(tx_full), .tx_overflow(tx_overflow), .rx_push(rx_push),
        .rx_data(rx_data), .rx_pop(rx_pop), .rx_out(rx_out),
        .rx_count(rx_count), .rx_full(rx_full), .rx_overflow(rx_overflow),
        .rx_timeout(rx_timeout), .tx_empty_irq(tx_empty_irq),
        .rx_ready_irq(rx_ready_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One control write; returns at the falling edge after the capturing edge.
    task automatic wr_ctl(input logic [7:0] d);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] d);
        tx_push = 1'b1; tx_data = d;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] d);
        rx_push = 1'b1; rx_data = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pop_tx();
        tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rdata", cfg_rdata, 0);
        chk("R1 tx_count", tx_count, 0);
        chk("R1 rx_count", rx_count, 0);
        chk("R1 ovf", {tx_overflow, rx_overflow}, 0);
        chk("R1 tx_empty", tx_empty_irq, 1);
        chk("R1 rx_ready", rx_ready_irq, 0);
    endtask

    task automatic t_order();
        wr_ctl(8'h01);
        push_tx(8'hA1); push_tx(8'hB2); push_tx(8'hC3);
        chk("R11 count", tx_count, 3);
        chk("R11 first", tx_out, 8'hA1);
        pop_tx();
        chk("R11 second", tx_out, 8'hB2);
        pop_tx();
        chk("R11 third", tx_out, 8'hC3);
    endtask

    task automatic t_single_and_txclr();
        wr_ctl(8'h05);
        @(negedge clk);
        wr_ctl(8'h00);
        push_tx(8'h11);
        chk("R6 count one", tx_count, 1);
        chk("R7 tx_empty low", tx_empty_irq, 0);
        push_tx(8'h22);
        chk("R6 second dropped", tx_count, 1);
        chk("R6 overflow", tx_overflow, 1);
        chk("R6 kept first", tx_out, 8'h11);
        push_rx(8'h33);
        wr_ctl(8'h05);
        chk("R4 pending bit", cfg_rdata[2], 1);
        @(negedge clk);
        chk("R4 bit self-clears", cfg_rdata[2], 0);
        chk("R4 tx_count", tx_count, 0);
        chk("R4 tx_overflow", tx_overflow, 0);
        chk("R4 rx untouched", rx_count, 1);
    endtask

    task automatic t_gated();
        wr_ctl(8'h39);
        wr_ctl(8'h06);
        chk("R2 readback", cfg_rdata, 8'h38);
        @(negedge clk);
        chk("R2 rx not cleared", rx_count, 1);
        chk("R2 tx unchanged", tx_count, 0);
    endtask

    task automatic t_mode0();
        wr_ctl(8'h01);
        chk("R7 rx_ready one char", rx_ready_irq, 1);
        pop_rx();
        chk("R7 rx_ready empty", rx_ready_irq, 0);
        rx_timeout = 1'b1;
        @(negedge clk);
        chk("R7 timeout ignored", rx_ready_irq, 0);
        rx_timeout = 1'b0;
    endtask

    task automatic t_tx_levels();
        wr_ctl(8'h09);
        for (int i = 0; i < 15; i++) push_tx(8'(i));
        chk("R8 15 below 16", tx_empty_irq, 1);
        push_tx(8'h0F);
        chk("R8 16 at level", tx_empty_irq, 0);
        wr_ctl(8'h19);
        chk("R8 code01 level 8", tx_empty_irq, 0);
        wr_ctl(8'h29);
        chk("R8 code10 level 24", tx_empty_irq, 1);
        wr_ctl(8'h39);
        chk("R8 code11 level 30", tx_empty_irq, 1);
        chk("R8 count kept", tx_count, 16);
    endtask

    task automatic t_rx_block();
        wr_ctl(8'h0B);
        @(negedge clk);
        chk("R3 rx empty", rx_count, 0);
        for (int i = 0; i < 7; i++) push_rx(8'(i));
        chk("R9 below trigger", rx_ready_irq, 0);
        rx_timeout = 1'b1;
        @(negedge clk);
        chk("R9 timeout", rx_ready_irq, 1);
        rx_timeout = 1'b0;
        @(negedge clk);
        chk("R9 timeout gone", rx_ready_irq, 0);
        push_rx(8'h07);
        chk("R9 at trigger", rx_ready_irq, 1);
        for (int i = 8; i < 64; i++) push_rx(8'(i));
        chk("R10 fills to 64", rx_count, 64);
        chk("R10 full", rx_full, 1);
        chk("R10 no overflow yet", rx_overflow, 0);
        push_rx(8'hEE);
        chk("R10 dropped", rx_count, 64);
        chk("R10 overflow sticky", rx_overflow, 1);
        @(negedge clk);
        chk("R10 overflow held", rx_overflow, 1);
        chk("R11 oldest rx", rx_out, 0);
    endtask

    task automatic t_clear_vs_push();
        cfg_wr = 1'b1; cfg_wdata = 8'h0B;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk("R3 pending bit", cfg_rdata[1], 1);
        chk("R3 tx untouched before", tx_count, 16);
        rx_push = 1'b1; rx_data = 8'h55;
        @(negedge clk);
        rx_push = 1'b0;
        chk("R5 clear beats push", rx_count, 0);
        chk("R3 bit self-clears", cfg_rdata[1], 0);
        chk("R3 overflow cleared", rx_overflow, 0);
        chk("R3 tx untouched", tx_count, 16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_single_and_txclr();
        t_gated();
        t_mode0();
        t_tx_levels();
        t_rx_block();
        t_clear_vs_push();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule